// File: doc/BRIEF.md
# Fast Clear Window Timer

This block runs the short decision interval that follows each acquisition gate. When the gate input falls, a window opens. A fast-clear strobe that arrives while the window is open throws away the event that was just converted, and the block reports this with a one-cycle discard pulse. If the window closes with no fast clear, the block issues a one-cycle commit pulse, which the surrounding logic uses to push the event into its multi-event buffer.

The window length comes from a 4-bit code held in a small configuration register. The length is (code+1) steps of 2048 ns, converted to system clock cycles and rounded up. A mode bit in the same register can hand the window over to an external level signal instead: the window then stays open for as long as that signal is high. Both configuration fields can be read back. The code and the mode are captured when the gate falls, so a write made during a window changes only later events.

Top module: `fcw_timer`

## Requirements
- R1: A synchronous active-low reset closes any open window and clears both outputs. It also sets the configuration code and the external-mode bit to 0, and an event that was open when reset arrived never produces an outcome.
- R2: When cfg_wr_i is high at a clock edge, cfg_code_o and cfg_ext_sel_o show the written values from the next cycle on. Without a write, they hold their values.
- R3: A window opens at the clock edge e1 where gate_i is sampled low after being sampled high at the previous edge. In timed mode it covers N = ceil((code+1) x STEP_NS / CLK_PERIOD_NS) edges, e2 to e(N+1). With the default parameters (STEP_NS 2048, period 4 ns), N = 512 x (code+1).
- R4: If no fast clear is accepted, commit_o goes high for exactly one cycle, following edge e(N+1) in timed mode.
- R5: A fast_clear_i sampled high at any window edge, including the last one, ends the window. discard_o then goes high for one cycle after that edge, and that event gets no commit.
- R6: A fast_clear_i sampled while no window is open has no effect and produces no discard.
- R7: A falling edge of gate_i while a window is open is ignored and never starts a second event.
- R8: If the external-mode bit is 1 when the gate falls, the window stays open from e2 onward while ext_win_i is high. At the first window edge where ext_win_i is sampled low and no fast clear is present, commit_o pulses after that edge. A fast clear in this mode discards as in R5.
- R9: The code and the mode in force are the ones held at e1. A configuration write during the window does not change the current window.
- R10: commit_o and discard_o are never high together, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_i | input | 1 | Write strobe for the configuration register |
| cfg_code_i | input | 4 | Window length code to write |
| cfg_ext_sel_i | input | 1 | External-mode bit to write (1 = external window) |
| gate_i | input | 1 | Acquisition gate; the window opens when it falls |
| fast_clear_i | input | 1 | Fast-clear request, sampled every cycle |
| ext_win_i | input | 1 | External window level, used in external mode |
| commit_o | output | 1 | One-cycle pulse: event goes to the multi-event buffer |
| discard_o | output | 1 | One-cycle pulse: event was fast-cleared |
| cfg_code_o | output | 4 | Readback of the window code |
| cfg_ext_sel_o | output | 1 | Readback of the external-mode bit |

## Verification
A counter loaded with a wrong value, or decremented at the wrong rate, moves the commit pulse by whole cycles. The bench measures the exact edge of that pulse for the smallest, a middle and the largest code. A state machine that fails to return to idle, or that re-arms on a gate fall inside the window, shows up either as a fast clear that is accepted outside the window or as a second commit within one window length. A wrong captured code or mode shows up as soon as the window ends, when a mid-window configuration write or a held external window would move the outcome edge.

// File: rtl/fcw_pkg.sv
// Package: shared state encoding and window-length arithmetic for the
// fast clear window timer. Assumes all time quantities are in whole ns.
package fcw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TIMED = 2'd1,
        ST_EXT   = 2'd2
    } fcw_state_t;

    // Window length in clock cycles for a code, rounded up so it is never short.
    function automatic int unsigned win_cycles(input int unsigned code,
                                               input int unsigned step_ns,
                                               input int unsigned period_ns);
        return ((code + 1) * step_ns + period_ns - 1) / period_ns;
    endfunction

endpackage

// File: rtl/fcw_edge_det.sv
// Module: detects a falling edge on the gate input.
// Assumes gate_i is already synchronous to clk. The flag is combinational:
// it is high in the cycle where gate_i is low and was high at the last edge.
module fcw_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic fall_o
);
    logic sig_q;

    // Hold last sampled level of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    // Falling edge when previous was high and current is low.
    assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/fcw_cfg_reg.sv
// Module: configuration register for window code and external-mode bit.
// Assumes a single-cycle write strobe; outputs are the stored values.
module fcw_cfg_reg #(
    parameter int unsigned CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              ext_sel_i,
    output logic [CODE_W-1:0] code_o,
    output logic              ext_sel_o
);
    // Store written fields; reset clears both to 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o    <= '0;
            ext_sel_o <= 1'b0;
        end else if (wr_i) begin
            code_o    <= code_i;
            ext_sel_o <= ext_sel_i;
        end
    end
endmodule

// File: rtl/fcw_window_cnt.sv
// Module: loadable down counter that times the on-board window.
// Assumes load has priority over decrement; stops at zero.
module fcw_window_cnt #(
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load the window length or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (load_i)                cnt_q <= load_val_i;
        else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
    end

    // Flag the last cycle of the window.
    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fcw_ctrl.sv
// Module: window state machine. Opens a timed or external window on a
// gate fall, resolves it to a commit or a discard pulse.
// Assumes fall_i comes from fcw_edge_det and zero_i from fcw_window_cnt.
module fcw_ctrl #(
    parameter int unsigned CODE_W        = 4,
    parameter int unsigned CNT_W         = 13,
    parameter int unsigned STEP_NS       = 2048,
    parameter int unsigned CLK_PERIOD_NS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              fast_clear_i,
    input  logic              ext_win_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              ext_sel_i,
    input  logic              zero_i,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic              dec_o,
    output logic              win_open_o,
    output logic              commit_o,
    output logic              discard_o
);
    import fcw_pkg::*;

    fcw_state_t state_q;

    // Counter control: load at the opening edge in timed mode, count while timed.
    assign load_o     = (state_q == ST_IDLE) && fall_i && !ext_sel_i;
    assign load_val_o = CNT_W'(win_cycles(32'(code_i), STEP_NS, CLK_PERIOD_NS) - 1);
    assign dec_o      = (state_q == ST_TIMED);
    assign win_open_o = (state_q != ST_IDLE);

    // Advance the window state and register the one-cycle outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            commit_o  <= 1'b0;
            discard_o <= 1'b0;
        end else begin
            commit_o  <= 1'b0;
            discard_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (fall_i) state_q <= ext_sel_i ? ST_EXT : ST_TIMED;
                end
                ST_TIMED: begin
                    if (fast_clear_i) begin
                        discard_o <= 1'b1;
                        state_q   <= ST_IDLE;
                    end else if (zero_i) begin
                        commit_o  <= 1'b1;
                        state_q   <= ST_IDLE;
                    end
                end
                ST_EXT: begin
                    if (fast_clear_i) begin
                        discard_o <= 1'b1;
                        state_q   <= ST_IDLE;
                    end else if (!ext_win_i) begin
                        commit_o  <= 1'b1;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fcw_timer.sv
// Module: top of the fast clear window timer. Ties together the gate edge
// detector, configuration register, window counter and control FSM.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module fcw_timer #(
    parameter int unsigned CODE_W        = 4,
    parameter int unsigned STEP_NS       = 2048,
    parameter int unsigned CLK_PERIOD_NS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic [CODE_W-1:0] cfg_code_i,
    input  logic              cfg_ext_sel_i,
    input  logic              gate_i,
    input  logic              fast_clear_i,
    input  logic              ext_win_i,
    output logic              commit_o,
    output logic              discard_o,
    output logic [CODE_W-1:0] cfg_code_o,
    output logic              cfg_ext_sel_o
);
    localparam int unsigned NUM_CODES = 2 ** CODE_W;
    localparam int unsigned MAX_CYC   =
        fcw_pkg::win_cycles(NUM_CODES - 1, STEP_NS, CLK_PERIOD_NS);
    localparam int unsigned CNT_W     = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic             gate_fall;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_load_val;
    logic             cnt_dec;
    logic             cnt_zero;
    logic             win_open;

    fcw_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (gate_i),
        .fall_o (gate_fall)
    );

    fcw_cfg_reg #(.CODE_W(CODE_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (cfg_wr_i),
        .code_i    (cfg_code_i),
        .ext_sel_i (cfg_ext_sel_i),
        .code_o    (cfg_code_o),
        .ext_sel_o (cfg_ext_sel_o)
    );

    fcw_window_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (cnt_load_val),
        .dec_i      (cnt_dec),
        .zero_o     (cnt_zero)
    );

    fcw_ctrl #(
        .CODE_W        (CODE_W),
        .CNT_W         (CNT_W),
        .STEP_NS       (STEP_NS),
        .CLK_PERIOD_NS (CLK_PERIOD_NS)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .fall_i       (gate_fall),
        .fast_clear_i (fast_clear_i),
        .ext_win_i    (ext_win_i),
        .code_i       (cfg_code_o),
        .ext_sel_i    (cfg_ext_sel_o),
        .zero_i       (cnt_zero),
        .load_o       (cnt_load),
        .load_val_o   (cnt_load_val),
        .dec_o        (cnt_dec),
        .win_open_o   (win_open),
        .commit_o     (commit_o),
        .discard_o    (discard_o)
    );
endmodule

// File: rtl/fcw_timer_chk.sv
// Module: assertion checker for fcw_timer, attached with bind below.
// Assumes access to the top's ports and its internal win_open signal.
module fcw_timer_chk #(
    parameter int unsigned CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_i,
    input logic [CODE_W-1:0] cfg_code_i,
    input logic              cfg_ext_sel_i,
    input logic              fast_clear_i,
    input logic              commit_o,
    input logic              discard_o,
    input logic [CODE_W-1:0] cfg_code_o,
    input logic              cfg_ext_sel_o,
    input logic              win_open
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!commit_o && !discard_o && !win_open &&
                    cfg_code_o == '0 && !cfg_ext_sel_o));

    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_i |=> (cfg_code_o == $past(cfg_code_i) &&
                      cfg_ext_sel_o == $past(cfg_ext_sel_i)));

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_i |=> ($stable(cfg_code_o) && $stable(cfg_ext_sel_o)));

    assert_outcome_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o || discard_o) |-> $past(win_open));

    assert_discard_by_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        discard_o |-> $past(fast_clear_i));

    assert_idle_clear_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && fast_clear_i) |=> !discard_o);

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && discard_o));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o || discard_o) |=> !(commit_o || discard_o));
endmodule

bind fcw_timer fcw_timer_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/fcw_timer_tb.sv
// Directed bench for fcw_timer: one task per scenario, each self-checking.
module fcw_timer_tb;
    localparam int unsigned STEP_NS = 2048;
    localparam int unsigned PER_NS  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_code = 4'd0;
    logic       cfg_sel = 1'b0;
    logic       gate = 1'b0;
    logic       fc = 1'b0;
    logic       ext_win = 1'b0;
    logic       commit_o, discard_o, cfg_sel_o;
    logic [3:0] cfg_code_o;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    fcw_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_code_i(cfg_code),
        .cfg_ext_sel_i(cfg_sel), .gate_i(gate), .fast_clear_i(fc),
        .ext_win_i(ext_win), .commit_o(commit_o), .discard_o(discard_o),
        .cfg_code_o(cfg_code_o), .cfg_ext_sel_o(cfg_sel_o)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run is a failed check and still reaches the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            miscompares = miscompares + 1;
            $display("FAIL watchdog: got %0d cycles expected below 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    function automatic int exp_len(input int code);
        return ((code + 1) * STEP_NS + PER_NS - 1) / PER_NS;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait for an outcome pulse; returns edges counted (0 if none).
    task automatic wait_outcome(input int limit, output int n, output int com, output int dis);
        n = 0; com = 0; dis = 0;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (commit_o || discard_o) begin
                n = i; com = int'(commit_o); dis = int'(discard_o);
                break;
            end
        end
    endtask

    task automatic write_cfg(input int code, input bit sel);
        cfg_code = 4'(code); cfg_sel = sel; cfg_wr = 1'b1;
        cyc(1);
        cfg_wr = 1'b0;
    endtask

    task automatic drop_gate();
        gate = 1'b1;
        cyc(1);
        gate = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(3);
        chk("R1", "commit in reset", int'(commit_o), 0);
        chk("R1", "discard in reset", int'(discard_o), 0);
        chk("R1", "code after reset", int'(cfg_code_o), 0);
        chk("R1", "ext sel after reset", int'(cfg_sel_o), 0);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic t_cfg_readback();
        write_cfg(9, 1'b1);
        chk("R2", "code readback", int'(cfg_code_o), 9);
        chk("R2", "sel readback", int'(cfg_sel_o), 1);
        cfg_code = 4'd3; cfg_sel = 1'b0;
        cyc(3);
        chk("R2", "code held without write", int'(cfg_code_o), 9);
        write_cfg(0, 1'b0);
        chk("R2", "code rewrite", int'(cfg_code_o), 0);
    endtask

    task automatic t_window_len(input int code);
        int n, com, dis;
        write_cfg(code, 1'b0);
        drop_gate();
        wait_outcome(exp_len(code) + 10, n, com, dis);
        chk("R3", $sformatf("window edges code %0d", code), n, exp_len(code) + 1);
        chk("R4", "commit pulse", com, 1);
        cyc(1);
        chk("R10", "commit one cycle", int'(commit_o), 0);
    endtask

    task automatic t_fast_clear(input int code, input int j);
        int n, com, dis;
        write_cfg(code, 1'b0);
        drop_gate();
        wait_outcome(j, n, com, dis);
        chk("R5", "no outcome before clear", n, 0);
        fc = 1'b1;
        @(posedge clk); @(negedge clk);
        fc = 1'b0;
        chk("R5", $sformatf("discard after clear at %0d", j), int'(discard_o), 1);
        chk("R10", "no commit with discard", int'(commit_o), 0);
        wait_outcome(exp_len(code) + 5, n, com, dis);
        chk("R5", "no later commit", n, 0);
    endtask

    task automatic t_clear_outside();
        int n, com, dis;
        fc = 1'b1;
        cyc(4);
        fc = 1'b0;
        chk("R6", "idle clear no discard", int'(discard_o), 0);
        write_cfg(0, 1'b0);
        drop_gate();
        wait_outcome(exp_len(0) + 5, n, com, dis);
        chk("R6", "commit before late clear", com, 1);
        fc = 1'b1;
        wait_outcome(5, n, com, dis);
        fc = 1'b0;
        chk("R6", "late clear ignored", n, 0);
    endtask

    task automatic t_gate_in_window();
        int n, com, dis;
        write_cfg(0, 1'b0);
        drop_gate();
        cyc(100);
        drop_gate();
        wait_outcome(exp_len(0) + 10, n, com, dis);
        chk("R7", "commit edge unchanged", n, exp_len(0) + 1 - 101);
        wait_outcome(exp_len(0) + 50, n, com, dis);
        chk("R7", "no second event", n, 0);
    endtask

    task automatic t_latch();
        int n, com, dis;
        write_cfg(1, 1'b0);
        drop_gate();
        write_cfg(15, 1'b1);
        wait_outcome(exp_len(15), n, com, dis);
        chk("R9", "window keeps code at gate fall", n, exp_len(1));
        chk("R9", "timed commit despite mode write", com, 1);
        chk("R9", "readback after mid-window write", int'(cfg_code_o), 15);
    endtask

    task automatic t_ext();
        int n, com, dis;
        write_cfg(0, 1'b1);
        ext_win = 1'b1;
        drop_gate();
        wait_outcome(2000, n, com, dis);
        chk("R8", "external window held open", n, 0);
        ext_win = 1'b0;
        wait_outcome(5, n, com, dis);
        chk("R8", "commit after external close", n, 1);
        chk("R8", "commit kind", com, 1);
        drop_gate();
        wait_outcome(5, n, com, dis);
        chk("R8", "external already low", n, 2);
        ext_win = 1'b1;
        drop_gate();
        cyc(5);
        fc = 1'b1;
        wait_outcome(3, n, com, dis);
        fc = 1'b0;
        chk("R8", "external discard", dis, 1);
        ext_win = 1'b0;
        wait_outcome(10, n, com, dis);
        chk("R8", "no commit after external discard", n, 0);
    endtask

    task automatic t_reset_mid();
        int n, com, dis;
        write_cfg(2, 1'b0);
        drop_gate();
        cyc(100);
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        chk("R1", "code cleared by reset", int'(cfg_code_o), 0);
        wait_outcome(exp_len(2) + 10, n, com, dis);
        chk("R1", "aborted event silent", n, 0);
    endtask

    initial begin
        cyc(1);
        t_reset();
        t_cfg_readback();
        t_window_len(0);
        t_window_len(3);
        t_window_len(15);
        t_fast_clear(0, 1);
        t_fast_clear(0, exp_len(0));
        t_fast_clear(4, 700);
        t_clear_outside();
        t_gate_in_window();
        t_latch();
        t_ext();
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule